// File: doc/BRIEF.md
# Bipolar Line Receive Decoder with Rail Output Formatting

This block sits between a receive slicer and the system side of a line interface. Every cycle of the recovered symbol clock it samples a positive and a negative rail pulse. It then decodes the pulse stream as plain alternate mark inversion, or it undoes the zero-substitution codes of the 1.544 Mb/s (eight-zero substitution) or 2.048 Mb/s (four-zero substitution) line formats. Decoded output is single-rail data together with a code-violation flag. The block can also retime the rails unchanged onto two outputs, or pass the slicer rails straight through with no retiming.

A mode state machine registers the configuration. It has the states OFF (powered down), AMI (plain decode), SUBST (substitution decode), DUAL (retimed rails) and SLICE (raw pass-through). Reset enters OFF. On each clock edge it makes one of these transitions: to OFF while power-down is set, otherwise to AMI, SUBST, DUAL or SLICE according to the 2-bit mode field. A 2-bit mode value of 00 selects AMI, 01 SUBST, 10 DUAL and 11 SLICE. The output clock, data inversion and loss-of-signal gating are applied at the output stage. Loss of signal is detected elsewhere and is only gated here.

Top module: `rx_line_decoder`

## Requirements
- R1: cfg_mode 00 selects single-rail plain decoding, 01 selects single-rail substitution decoding (eight-zero code when cfg_e1=0, four-zero code when cfg_e1=1), 10 selects retimed dual-rail output and 11 selects slicer pass-through.
- R2: In modes 00, 01 and 10, the symbol sampled at clock edge k appears on rd_pos/rd_neg right after edge k+8, for data and violation flag alike.
- R3: In single-rail modes, rd_pos is 1 for a pulse on exactly one rail. rd_neg is 1 when a pulse has the same polarity as the previous pulse, or when both rails are high, in which case rd_pos is 0. The first pulse after reset is never a violation.
- R4: With the eight-zero code, the sequence 0,0,0,V,B,0,V,B is output as eight zeros with no violation flagged. A stray violation outside that pattern is flagged.
- R5: With the four-zero code, 0,0,0,V and B,0,0,V are each output as four zeros with no violation flagged. A stray violation is flagged.
- R6: In mode 10, rd_pos and rd_neg carry the sampled positive and negative rails unchanged, with no substitution removed.
- R7: In mode 11, rd_pos and rd_neg follow rx_pos and rx_neg combinationally, and rclk_out equals rx_pos XOR rx_neg.
- R8: In modes 00 to 10, rclk_out equals clk when cfg_edge_fall=0, so data changes on its rising edge. It equals the inverse of clk when cfg_edge_fall=1, so data changes on its falling edge.
- R9: cfg_data_inv inverts the data outputs: rd_pos in single-rail modes, and both rails in modes 10 and 11. The violation flag is never inverted.
- R10: While powered down (from the first edge with cfg_pwr_down=1 until the first edge with it cleared), rclk_out, rd_pos, rd_neg and los_out are all 0.
- R11: When powered up, los_out equals los_in.
- R12: During reset all four outputs are 0. The first edge after release applies the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pos | input | 1 | Positive rail pulse from slicer |
| rx_neg | input | 1 | Negative rail pulse from slicer |
| los_in | input | 1 | Loss-of-signal indication from detector |
| cfg_mode | input | 2 | Decode and output mode select |
| cfg_e1 | input | 1 | 1: four-zero substitution code, 0: eight-zero code |
| cfg_edge_fall | input | 1 | 1: data changes on falling rclk_out edge |
| cfg_data_inv | input | 1 | Invert data outputs |
| cfg_pwr_down | input | 1 | Power-down, forces outputs low |
| rclk_out | output | 1 | Receive clock to system side |
| rd_pos | output | 1 | Decoded data or positive rail |
| rd_neg | output | 1 | Code-violation flag or negative rail |
| los_out | output | 1 | Gated loss-of-signal |

## Verification
The bench builds the block with the default window length of 8. This keeps the stated latency exact and makes one window span a whole eight-zero pattern. The bench encodes pseudo-random streams with long zero runs in all three line codes, feeds each one through and compares every output symbol at its exact latency. The small window also lets the bench sweep every rail combination, inversion, edge selection and mode under power-down exhaustively. Hand-built short streams place stray violations and both-rail pulses right after reset.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_AMI,
        ST_SUBST,
        ST_DUAL,
        ST_SLICE
    } rail_state_e;

    typedef enum logic [1:0] {
        SUB_NONE,
        SUB_B8ZS,
        SUB_HDB3
    } sub_sel_e;

    typedef struct packed {
        logic pos;
        logic neg;
        logic viol;
    } line_sym_t;

    localparam logic [1:0] MODE_AMI   = 2'b00;
    localparam logic [1:0] MODE_SUBST = 2'b01;
    localparam logic [1:0] MODE_DUAL  = 2'b10;
    localparam logic [1:0] MODE_SLICE = 2'b11;

    localparam int EIGHT_SPAN = 8;
    localparam int FOUR_SPAN  = 4;

    function automatic logic sym_is_space(line_sym_t s);
        return (s == '0);
    endfunction

    function automatic logic sym_is_vmark(line_sym_t s);
        return (s.pos ^ s.neg) & s.viol;
    endfunction

    function automatic logic sym_is_bmark(line_sym_t s);
        return (s.pos ^ s.neg) & ~s.viol;
    endfunction

endpackage

// File: rtl/rdec_pol_track.sv
module rdec_pol_track
    import rdec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_pos,
    input  logic      rx_neg,
    output line_sym_t sym_o
);

    logic seen_mark_q;
    logic last_pos_q;
    logic is_mark;

    assign is_mark = rx_pos ^ rx_neg;

    always_comb begin
        sym_o.pos  = rx_pos;
        sym_o.neg  = rx_neg;
        sym_o.viol = (rx_pos & rx_neg) |
                     (is_mark & seen_mark_q & (rx_pos == last_pos_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_mark_q <= 1'b0;
            last_pos_q  <= 1'b0;
        end else if (is_mark) begin
            seen_mark_q <= 1'b1;
            last_pos_q  <= rx_pos;
        end
    end

endmodule

// File: rtl/rdec_sub_window.sv
module rdec_sub_window
    import rdec_pkg::*;
#(
    parameter int WIN_LEN = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  sub_sel_e  sub_sel,
    input  line_sym_t sym_i,
    output line_sym_t sym_o
);

    localparam int LAST = WIN_LEN - 1;

    line_sym_t          win_q [WIN_LEN];
    line_sym_t          cand  [WIN_LEN];
    logic [WIN_LEN-1:0] clr_v;
    line_sym_t          out_q;
    logic               hit_eight;
    logic               hit_four;

    always_comb begin
        cand[0] = sym_i;
        for (int i = 1; i < WIN_LEN; i++) begin
            cand[i] = win_q[i-1];
        end
    end

    always_comb begin
        hit_eight = (sub_sel == SUB_B8ZS) &&
                    sym_is_space(cand[7]) && sym_is_space(cand[6]) &&
                    sym_is_space(cand[5]) && sym_is_vmark(cand[4]) &&
                    sym_is_bmark(cand[3]) && sym_is_space(cand[2]) &&
                    sym_is_vmark(cand[1]) && sym_is_bmark(cand[0]);
        hit_four  = (sub_sel == SUB_HDB3) &&
                    sym_is_vmark(cand[0]) && sym_is_space(cand[1]) &&
                    sym_is_space(cand[2]) &&
                    (sym_is_space(cand[3]) || sym_is_bmark(cand[3]));
    end

    generate
        for (genvar g = 0; g < WIN_LEN; g++) begin : g_clr
            localparam logic IN_EIGHT = (g < EIGHT_SPAN);
            localparam logic IN_FOUR  = (g < FOUR_SPAN);
            assign clr_v[g] = (hit_eight & IN_EIGHT) | (hit_four & IN_FOUR);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_LEN; i++) begin
                win_q[i] <= '0;
            end
            out_q <= '0;
        end else begin
            for (int i = 0; i < WIN_LEN; i++) begin
                win_q[i] <= clr_v[i] ? '0 : cand[i];
            end
            out_q <= win_q[LAST];
        end
    end

    assign sym_o = out_q;

    // R3: a flagged violation always carries a pulse
    a_r3_flag_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.viol |-> (out_q.pos || out_q.neg));

    // R3: both rails high is always flagged on leaving the window
    a_r3_dual_high_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.pos && out_q.neg) |-> out_q.viol);

endmodule

// File: rtl/rdec_rail_fsm.sv
module rdec_rail_fsm
    import rdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_mode,
    input  logic        cfg_pwr_down,
    output rail_state_e state_o
);

    rail_state_e state_q;
    rail_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (cfg_pwr_down) begin
            state_d = ST_OFF;
        end else begin
            unique case (cfg_mode)
                MODE_AMI:   state_d = ST_AMI;
                MODE_SUBST: state_d = ST_SUBST;
                MODE_DUAL:  state_d = ST_DUAL;
                MODE_SLICE: state_d = ST_SLICE;
                default:    state_d = ST_OFF;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/rx_line_decoder.sv
module rx_line_decoder
    import rdec_pkg::*;
#(
    parameter int WIN_LEN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_pos,
    input  logic       rx_neg,
    input  logic       los_in,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_e1,
    input  logic       cfg_edge_fall,
    input  logic       cfg_data_inv,
    input  logic       cfg_pwr_down,
    output logic       rclk_out,
    output logic       rd_pos,
    output logic       rd_neg,
    output logic       los_out
);

    line_sym_t   line_sym;
    line_sym_t   dec_sym;
    rail_state_e rail_state;
    sub_sel_e    sub_sel;
    logic        settled_q;
    logic        line_clk;

    rdec_pol_track u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_pos (rx_pos),
        .rx_neg (rx_neg),
        .sym_o  (line_sym)
    );

    rdec_rail_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode     (cfg_mode),
        .cfg_pwr_down (cfg_pwr_down),
        .state_o      (rail_state)
    );

    always_comb begin
        if (rail_state == ST_SUBST) begin
            sub_sel = cfg_e1 ? SUB_HDB3 : SUB_B8ZS;
        end else begin
            sub_sel = SUB_NONE;
        end
    end

    rdec_sub_window #(
        .WIN_LEN (WIN_LEN)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_sel (sub_sel),
        .sym_i   (line_sym),
        .sym_o   (dec_sym)
    );

    assign line_clk = cfg_edge_fall ? ~clk : clk;

    always_comb begin
        rclk_out = 1'b0;
        rd_pos   = 1'b0;
        rd_neg   = 1'b0;
        los_out  = 1'b0;
        unique case (rail_state)
            ST_OFF: begin
                rclk_out = 1'b0;
            end
            ST_AMI, ST_SUBST: begin
                rclk_out = line_clk;
                rd_pos   = (dec_sym.pos ^ dec_sym.neg) ^ cfg_data_inv;
                rd_neg   = dec_sym.viol;
                los_out  = los_in;
            end
            ST_DUAL: begin
                rclk_out = line_clk;
                rd_pos   = dec_sym.pos ^ cfg_data_inv;
                rd_neg   = dec_sym.neg ^ cfg_data_inv;
                los_out  = los_in;
            end
            ST_SLICE: begin
                rclk_out = rx_pos ^ rx_neg;
                rd_pos   = rx_pos ^ cfg_data_inv;
                rd_neg   = rx_neg ^ cfg_data_inv;
                los_out  = los_in;
            end
            default: begin
                rclk_out = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settled_q <= 1'b0;
        end else begin
            settled_q <= 1'b1;
        end
    end

    // R10: power-down silences every output from the next edge
    a_r10_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pwr_down |=> (!rclk_out && !rd_pos && !rd_neg && !los_out));

    // R11: loss of signal passes when powered up
    a_r11_los_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (settled_q && !cfg_pwr_down) |=> (los_out == los_in));

    // R7: pass-through clock is the rail XOR
    a_r7_slice_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (settled_q && !cfg_pwr_down && cfg_mode == MODE_SLICE)
            |=> (rclk_out == (rx_pos ^ rx_neg)));

endmodule

// File: tb/sim_rx_line_decoder.sv
module sim_rx_line_decoder;

    localparam int NMAX = 256;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_pos, rx_neg, los_in;
    logic [1:0] cfg_mode;
    logic       cfg_e1, cfg_edge_fall, cfg_data_inv, cfg_pwr_down;
    logic       rclk_out, rd_pos, rd_neg, los_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    logic dbit [NMAX];
    logic sp   [NMAX];
    logic sn   [NMAX];
    logic xa   [NMAX];
    logic xb   [NMAX];

    always #4 clk = ~clk;

    rx_line_decoder u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_pos        (rx_pos),
        .rx_neg        (rx_neg),
        .los_in        (los_in),
        .cfg_mode      (cfg_mode),
        .cfg_e1        (cfg_e1),
        .cfg_edge_fall (cfg_edge_fall),
        .cfg_data_inv  (cfg_data_inv),
        .cfg_pwr_down  (cfg_pwr_down),
        .rclk_out      (rclk_out),
        .rd_pos        (rd_pos),
        .rd_neg        (rd_neg),
        .los_out       (los_out)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        rx_pos = 1'b0;
        rx_neg = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic gen_data(input int len, input logic [15:0] seed);
        logic [15:0] lf;
        lf = seed;
        for (int i = 0; i < len; i++) begin
            int k;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            k  = i % 29;
            dbit[i] = (k >= 18 && k < 27) ? 1'b0 : lf[0];
        end
        dbit[0] = 1'b1;
    endtask

    task automatic put(input int i, input logic mark, input logic p);
        sp[i] = mark & p;
        sn[i] = mark & ~p;
    endtask

    task automatic enc_ami(input int len);
        logic lp;
        lp = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (dbit[i]) lp = ~lp;
            put(i, dbit[i], lp);
        end
    endtask

    task automatic enc_four(input int len);
        logic lp;
        int   nonv;
        int   i;
        lp = 1'b0; nonv = 0; i = 0;
        while (i < len) begin
            if (i + 3 < len && !dbit[i] && !dbit[i+1] && !dbit[i+2] && !dbit[i+3]) begin
                put(i+1, 1'b0, 1'b0);
                put(i+2, 1'b0, 1'b0);
                if (nonv % 2 == 1) begin
                    put(i, 1'b0, 1'b0);
                end else begin
                    lp = ~lp;
                    put(i, 1'b1, lp);
                end
                put(i+3, 1'b1, lp);
                nonv = 0;
                i += 4;
            end else begin
                if (dbit[i]) begin
                    lp = ~lp;
                    nonv++;
                end
                put(i, dbit[i], lp);
                i++;
            end
        end
    endtask

    task automatic enc_eight(input int len);
        logic lp;
        int   i;
        lp = 1'b0; i = 0;
        while (i < len) begin
            if (i + 7 < len && !dbit[i] && !dbit[i+1] && !dbit[i+2] && !dbit[i+3] &&
                !dbit[i+4] && !dbit[i+5] && !dbit[i+6] && !dbit[i+7]) begin
                put(i,   1'b0, 1'b0);
                put(i+1, 1'b0, 1'b0);
                put(i+2, 1'b0, 1'b0);
                put(i+3, 1'b1, lp);
                put(i+4, 1'b1, ~lp);
                put(i+5, 1'b0, 1'b0);
                put(i+6, 1'b1, ~lp);
                put(i+7, 1'b1, lp);
                i += 8;
            end else begin
                if (dbit[i]) lp = ~lp;
                put(i, dbit[i], lp);
                i++;
            end
        end
    endtask

    task automatic expect_single(input int len);
        for (int i = 0; i < len; i++) begin
            xa[i] = dbit[i] ^ cfg_data_inv;
            xb[i] = 1'b0;
        end
    endtask

    task automatic expect_rails(input int len);
        for (int i = 0; i < len; i++) begin
            xa[i] = sp[i] ^ cfg_data_inv;
            xb[i] = sn[i] ^ cfg_data_inv;
        end
    endtask

    // output after edge e+8 reflects the symbol sampled at edge e (R2)
    task automatic run_stream(input string tag, input int len);
        for (int e = 0; e < len + 9; e++) begin
            @(negedge clk);
            if (e >= 9) begin
                chk(tag, "rd_pos", rd_pos, xa[e-9]);
                chk(tag, "rd_neg", rd_neg, xb[e-9]);
            end
            rx_pos = (e < len) ? sp[e] : 1'b0;
            rx_neg = (e < len) ? sn[e] : 1'b0;
        end
    endtask

    task automatic start_mode(input logic [1:0] m, input logic e1, input logic inv);
        cfg_mode     = m;
        cfg_e1       = e1;
        cfg_data_inv = inv;
        do_reset();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not complete");
        report();
    end

    initial begin
        rst_n = 1'b0; rx_pos = 1'b1; rx_neg = 1'b0; los_in = 1'b1;
        cfg_mode = 2'b11; cfg_e1 = 1'b0; cfg_edge_fall = 1'b0;
        cfg_data_inv = 1'b0; cfg_pwr_down = 1'b0;

        // R12: outputs low while reset is held
        repeat (2) @(negedge clk);
        chk("R12", "rd_pos in reset", rd_pos, 1'b0);
        chk("R12", "rd_neg in reset", rd_neg, 1'b0);
        chk("R12", "rclk in reset", rclk_out, 1'b1 & 1'b0);
        chk("R12", "los in reset", los_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "rd_pos after first edge", rd_pos, 1'b1);
        chk("R11", "los after first edge", los_out, 1'b1);

        // R7 R9: exhaustive pass-through sweep
        for (int inv = 0; inv < 2; inv++) begin
            for (int p = 0; p < 2; p++) begin
                for (int n = 0; n < 2; n++) begin
                    @(negedge clk);
                    cfg_data_inv = inv[0]; rx_pos = p[0]; rx_neg = n[0];
                    #1;
                    chk("R7/R9", "slice rd_pos", rd_pos, p[0] ^ inv[0]);
                    chk("R7/R9", "slice rd_neg", rd_neg, n[0] ^ inv[0]);
                    chk("R7", "slice rclk", rclk_out, p[0] ^ n[0]);
                end
            end
        end
        cfg_data_inv = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;

        // R8: clock edge selection in every retimed mode, both phases
        for (int m = 0; m < 3; m++) begin
            for (int f = 0; f < 2; f++) begin
                @(negedge clk);
                cfg_mode = m[1:0]; cfg_edge_fall = f[0];
                @(negedge clk);
                chk("R8", "rclk low phase", rclk_out, f[0]);
                @(posedge clk);
                #2;
                chk("R8", "rclk high phase", rclk_out, ~f[0]);
            end
        end
        cfg_edge_fall = 1'b0;

        // R10 R11 R13: power-down in every mode, then release
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            cfg_mode = m[1:0]; cfg_pwr_down = 1'b1; rx_pos = 1'b1; los_in = 1'b1;
            cfg_data_inv = 1'b1;
            @(negedge clk);
            chk("R10", "pd rd_pos", rd_pos, 1'b0);
            chk("R10", "pd rd_neg", rd_neg, 1'b0);
            chk("R10", "pd rclk low", rclk_out, 1'b0);
            chk("R10", "pd los", los_out, 1'b0);
            @(posedge clk);
            #2;
            chk("R10", "pd rclk high", rclk_out, 1'b0);
            @(negedge clk);
            cfg_pwr_down = 1'b0;
            @(negedge clk);
            chk("R11", "los after pd", los_out, 1'b1);
            los_in = 1'b0;
            #1;
            chk("R11", "los cleared", los_out, 1'b0);
            los_in = 1'b1;
        end
        cfg_data_inv = 1'b0; rx_pos = 1'b0;

        // R1 R2 R3: plain decode of a random stream
        start_mode(2'b00, 1'b0, 1'b0);
        gen_data(240, 16'hACE1); enc_ami(240); expect_single(240);
        run_stream("R1/R2/R3 ami", 240);

        // R9: plain decode with data inversion
        start_mode(2'b00, 1'b0, 1'b1);
        gen_data(240, 16'h1D2B); enc_ami(240); expect_single(240);
        run_stream("R9 ami inverted", 240);

        // R5: four-zero substitution decode
        start_mode(2'b01, 1'b1, 1'b0);
        gen_data(240, 16'h5A3C); enc_four(240); expect_single(240);
        run_stream("R1/R5 four-zero", 240);

        // R4: eight-zero substitution decode
        start_mode(2'b01, 1'b0, 1'b0);
        gen_data(240, 16'h7E11); enc_eight(240); expect_single(240);
        run_stream("R1/R4 eight-zero", 240);

        // R6: dual rail keeps substitution pulses, plain and inverted
        start_mode(2'b10, 1'b0, 1'b0);
        gen_data(200, 16'h3B07); enc_eight(200); expect_rails(200);
        run_stream("R6 dual", 200);
        start_mode(2'b10, 1'b0, 1'b1);
        expect_rails(200);
        run_stream("R6/R9 dual inverted", 200);

        // R3: explicit violations and both-rail pulse
        start_mode(2'b00, 1'b0, 1'b0);
        put(0, 1, 1); put(1, 0, 0); put(2, 1, 1); put(3, 1, 0);
        sp[4] = 1'b1; sn[4] = 1'b1; put(5, 1, 1);
        xa[0] = 1; xa[1] = 0; xa[2] = 1; xa[3] = 1; xa[4] = 0; xa[5] = 1;
        xb[0] = 0; xb[1] = 0; xb[2] = 1; xb[3] = 0; xb[4] = 1; xb[5] = 0;
        run_stream("R3 violations", 6);

        // R5: stray violation in four-zero mode
        start_mode(2'b01, 1'b1, 1'b0);
        put(0, 1, 1); put(1, 1, 1); put(2, 1, 0);
        xa[0] = 1; xa[1] = 1; xa[2] = 1;
        xb[0] = 0; xb[1] = 1; xb[2] = 0;
        run_stream("R5 stray violation", 3);

        // R4: stray violation in eight-zero mode
        start_mode(2'b01, 1'b0, 1'b0);
        put(0, 1, 1); put(1, 0, 0); put(2, 0, 0); put(3, 0, 0); put(4, 1, 1);
        xa[0] = 1; xa[1] = 0; xa[2] = 0; xa[3] = 0; xa[4] = 1;
        xb[0] = 0; xb[1] = 0; xb[2] = 0; xb[3] = 0; xb[4] = 1;
        run_stream("R4 stray violation", 5);

        report();
    end

endmodule